// File: doc/BRIEF.md
# Wide Register Bridge

This block lets a host that only issues 32-bit register accesses reach a bank of 64-bit registers behind it. The host sees a small window: two 32-bit data holding registers (upper and lower half), a command register, an error-clearing register, a status register and an interrupt-enable register. Every wide access is started by writing the command word. Bit 31 of that word selects the direction, and the remaining bits give an absolute inner address. The inner bank occupies a contiguous run of addresses that starts at a parameterised base.

To store a value, the host first loads both halves and then writes a command with the direction bit set. The bridge then presents the joined 64-bit value, together with a one-cycle write strobe, to the bank. To fetch a value, the host writes a command with the direction bit clear. The bridge pulses a read strobe, captures the bank's answer into the two halves, and holds it there for the host to read at leisure.

A command whose address falls outside the bank performs no access. Instead it raises a sticky error flag, which the host checks after each command and clears through the reset register.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, both data halves, the command readback, the status word and the interrupt enable read as zero, and the bank strobes and `irq` are low.
- R2: The upper half is at byte offset 0x00 and holds bits 63:32. The lower half is at 0x04 and holds bits 31:0. A command written at 0x08 with bit 31 = 1 and a valid address drives `bk_wr` high for exactly the next cycle, with `bk_idx` equal to the address minus the base and `bk_wdata` equal to {upper, lower}.
- R3: A command with bit 31 = 0 and a valid address drives `bk_rd` high for exactly the next cycle. At the end of that cycle, bank bits 63:32 are loaded into the upper half and bits 31:0 into the lower half.
- R4: A command address in bits 30:0 is valid only when base <= address < base + BANK_REGS. Otherwise neither strobe is raised and status bit 31 (status at 0x1C) becomes 1.
- R5: The error flag stays set through later commands, valid or not, and through host writes to the status offset, which are ignored.
- R6: Any write to offset 0x18 clears the error flag. If that write lands in the cycle right after a command write, it also cancels that command, so no strobe is raised.
- R7: The data halves change only on a host write to their own offset or on a read command's capture. A read result stays readable across idle cycles, other register writes and commands that fail decode.
- R8: Bit 0 of offset 0x20 is a readable interrupt enable, and `irq` is high exactly while that enable and the error flag are both 1.
- R9: Offset 0x08 reads back the last command word written, and any offset not listed above reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host write strobe |
| hst_addr | input | AW | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for `hst_addr` (combinational) |
| irq | output | 1 | Error interrupt, gated by the enable |
| bk_wr | output | 1 | Bank write strobe |
| bk_rd | output | 1 | Bank read strobe |
| bk_idx | output | IW | Bank register index |
| bk_wdata | output | 64 | Bank write data |
| bk_rdata | input | 64 | Bank read data, valid in the `bk_rd` cycle |

## Verification
The hardest situation to reach is the narrow cancel window of R6. Here the error-clearing write must arrive in exactly the cycle after a command write, while that command is still pending. The bench issues its host writes back to back, with no idle cycle between them, so a command followed directly by a reset write lands in that cycle. It then reads the targeted bank register back to confirm that the old content survived. Decode failures just below the base and just past the top of the bank are also driven, and the bench counts the bank strobes to show that none of them leaked.

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter int AW = 6,
  parameter logic [30:0] BANK_BASE = 31'h0007_0000,
  parameter int BANK_REGS = 10,
  localparam int IW = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_wr,
  input  logic [AW-1:0] hst_addr,
  input  logic [31:0]   hst_wdata,
  output logic [31:0]   hst_rdata,
  output logic          irq,
  output logic          bk_wr,
  output logic          bk_rd,
  output logic [IW-1:0] bk_idx,
  output logic [63:0]   bk_wdata,
  input  logic [63:0]   bk_rdata
);

  localparam logic [AW-1:0] A_HI  = AW'(8'h00);
  localparam logic [AW-1:0] A_LO  = AW'(8'h04);
  localparam logic [AW-1:0] A_CMD = AW'(8'h08);
  localparam logic [AW-1:0] A_RST = AW'(8'h18);
  localparam logic [AW-1:0] A_STS = AW'(8'h1C);
  localparam logic [AW-1:0] A_IEN = AW'(8'h20);

  logic [31:0]   dh_q, dl_q, cmd_q;
  logic          pend_q, dir_q, err_q, ien_q;
  logic [IW-1:0] idx_q;

  wire wr_hi  = hst_wr && (hst_addr == A_HI);
  wire wr_lo  = hst_wr && (hst_addr == A_LO);
  wire wr_cmd = hst_wr && (hst_addr == A_CMD);
  wire wr_rst = hst_wr && (hst_addr == A_RST);
  wire wr_ien = hst_wr && (hst_addr == A_IEN);

  wire [30:0] off = hst_wdata[30:0] - BANK_BASE;
  wire        hit = (hst_wdata[30:0] >= BANK_BASE) && (off < 31'(BANK_REGS));
  wire        go  = pend_q && !wr_rst;

  assign bk_wr    = go && dir_q;
  assign bk_rd    = go && !dir_q;
  assign bk_idx   = idx_q;
  assign bk_wdata = {dh_q, dl_q};
  assign irq      = ien_q && err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dir_q  <= 1'b0;
      err_q  <= 1'b0;
      ien_q  <= 1'b0;
      idx_q  <= '0;
      cmd_q  <= '0;
    end else begin
      if (wr_ien) ien_q <= hst_wdata[0];
      if (wr_rst) begin
        err_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (wr_cmd) begin
        cmd_q  <= hst_wdata;
        pend_q <= hit;
        dir_q  <= hst_wdata[31];
        idx_q  <= off[IW-1:0];
        if (!hit) err_q <= 1'b1;
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dh_q <= '0;
      dl_q <= '0;
    end else if (bk_rd) begin
      dh_q <= bk_rdata[63:32];
      dl_q <= bk_rdata[31:0];
    end else begin
      if (wr_hi) dh_q <= hst_wdata;
      if (wr_lo) dl_q <= hst_wdata;
    end
  end

  always_comb begin
    case (hst_addr)
      A_HI:    hst_rdata = dh_q;
      A_LO:    hst_rdata = dl_q;
      A_CMD:   hst_rdata = cmd_q;
      A_STS:   hst_rdata = {err_q, 31'b0};
      A_IEN:   hst_rdata = {31'b0, ien_q};
      default: hst_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk #(
  parameter int AW = 6,
  parameter int BANK_REGS = 10,
  localparam int IW = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hst_wr,
  input logic [AW-1:0] hst_addr,
  input logic          cmd_dir,
  input logic          bk_wr,
  input logic          bk_rd,
  input logic [IW-1:0] bk_idx,
  input logic          err,
  input logic [31:0]   dh
);

  localparam logic [AW-1:0] A_HI  = AW'(8'h00);
  localparam logic [AW-1:0] A_CMD = AW'(8'h08);
  localparam logic [AW-1:0] A_RST = AW'(8'h18);

  wire rst_wr = hst_wr && (hst_addr == A_RST);

  AST_WR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bk_wr |-> $past(hst_wr && hst_addr == A_CMD && cmd_dir)) else $error("wr strobe w/o command"); // R2
  AST_RD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bk_rd |-> $past(hst_wr && hst_addr == A_CMD && !cmd_dir)) else $error("rd strobe w/o command"); // R3
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_wr || bk_rd) |-> (bk_idx < IW'(BANK_REGS))) else $error("index out of bank"); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !rst_wr) |=> err) else $error("error flag dropped"); // R5
  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> !err) else $error("reset write left error"); // R6
  AST_RST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |-> !(bk_wr || bk_rd)) else $error("strobe beside reset write"); // R6
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bk_rd && !(hst_wr && hst_addr == A_HI)) |=> $stable(dh)) else $error("upper half changed"); // R7

endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(.AW(AW), .BANK_REGS(BANK_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
  .cmd_dir(hst_wdata[31]), .bk_wr(bk_wr), .bk_rd(bk_rd), .bk_idx(bk_idx),
  .err(err_q), .dh(dh_q)
);

// File: tb/wide_reg_bridge_bench.sv
module wide_reg_bridge_bench;
  localparam int AW = 6;
  localparam int NREG = 10;
  localparam int IW = $clog2(NREG);
  localparam logic [31:0] BASE = 32'h0007_0000;
  localparam logic [31:0] WR = 32'h8000_0000;
  localparam logic [AW-1:0] A_HI = 6'h00, A_LO = 6'h04, A_CMD = 6'h08,
                            A_RST = 6'h18, A_STS = 6'h1C, A_IEN = 6'h20;
  localparam int NV = 5;
  localparam logic [67:0] VEC [NV] = '{
    {4'd0, 64'h0123_4567_89AB_CDEF},
    {4'd9, 64'hFEDC_BA98_7654_3210},
    {4'd2, 64'hDEAD_BEEF_0000_0001},
    {4'd5, 64'h8000_0000_0000_0000},
    {4'd7, 64'h0000_0001_FFFF_FFFF}};

  logic clk = 1'b0, rst_n = 1'b0, hst_wr = 1'b0;
  logic [AW-1:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic irq, bk_wr, bk_rd;
  logic [IW-1:0] bk_idx;
  logic [63:0] bk_wdata, bk_rdata;
  logic [63:0] bank [NREG];
  int nchk = 0, nerr = 0, nwr = 0, nrd = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wide_reg_bridge #(.AW(AW), .BANK_BASE(BASE[30:0]), .BANK_REGS(NREG)) u_wide_reg_bridge (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .irq(irq),
    .bk_wr(bk_wr), .bk_rd(bk_rd), .bk_idx(bk_idx),
    .bk_wdata(bk_wdata), .bk_rdata(bk_rdata));

  assign bk_rdata = bank[bk_idx];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
      nwr <= 0;
      nrd <= 0;
    end else begin
      if (bk_wr) begin
        bank[bk_idx] <= bk_wdata;
        nwr <= nwr + 1;
      end
      if (bk_rd) nrd <= nrd + 1;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [AW-1:0] a, input logic [31:0] d);
    hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    hst_addr = a;
    #1 d = hst_rdata;
  endtask

  task automatic fetch(input int idx, output logic [63:0] v);
    logic [31:0] h, l;
    hw(A_CMD, BASE + 32'(idx));
    @(negedge clk);
    rd(A_HI, h);
    rd(A_LO, l);
    v = {h, l};
  endtask

  initial begin
    logic [31:0] r;
    logic [63:0] v;
    int w0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_HI, r);  chk("R1 hi", 64'(r), 0);
    rd(A_LO, r);  chk("R1 lo", 64'(r), 0);
    rd(A_CMD, r); chk("R1 cmd", 64'(r), 0);
    rd(A_STS, r); chk("R1 sts", 64'(r), 0);
    rd(A_IEN, r); chk("R1 ien", 64'(r), 0);
    chk("R1 outs", {61'b0, irq, bk_wr, bk_rd}, 0);

    for (int k = 0; k < NV; k++) begin
      w0 = nwr;
      hw(A_HI, VEC[k][63:32]);
      hw(A_LO, VEC[k][31:0]);
      hw(A_CMD, WR | (BASE + 32'(VEC[k][67:64])));
      chk("R2 strobe", {63'b0, bk_wr}, 1);
      chk("R2 idx", 64'(bk_idx), 64'(VEC[k][67:64]));
      chk("R2 wdata", bk_wdata, VEC[k][63:0]);
      @(negedge clk);
      chk("R2 one pulse", 64'(nwr - w0), 1);
      chk("R2 no strobe after", {62'b0, bk_wr, bk_rd}, 0);
      hw(A_HI, 0);
      hw(A_LO, 0);
      r0 = nrd;
      fetch(int'(VEC[k][67:64]), v);
      chk("R3 readback", v, VEC[k][63:0]);
      chk("R3 one pulse", 64'(nrd - r0), 1);
      rd(A_STS, r); chk("R4 valid no err", 64'(r), 0);
    end

    w0 = nwr;
    hw(A_HI, 32'h1111_1111);
    hw(A_CMD, WR | (BASE + NREG));
    @(negedge clk);
    chk("R4 above top no write", 64'(nwr - w0), 0);
    rd(A_STS, r); chk("R4 err set", 64'(r), 64'h8000_0000);
    chk("R8 irq masked", {63'b0, irq}, 0);
    hw(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, r); chk("R8 ien read", 64'(r), 1);
    chk("R8 irq", {63'b0, irq}, 1);
    rd(A_CMD, r); chk("R9 cmd readback", 64'(r), 64'(WR | (BASE + NREG)));
    rd(6'h0C, r); chk("R9 hole 0C", 64'(r), 0);
    rd(6'h10, r); chk("R9 hole 10", 64'(r), 0);

    fetch(0, v);
    chk("R5 valid cmd works", v, VEC[0][63:0]);
    rd(A_STS, r); chk("R5 sticky after valid", 64'(r), 64'h8000_0000);
    hw(A_STS, 0);
    rd(A_STS, r); chk("R5 status write ignored", 64'(r), 64'h8000_0000);

    r0 = nrd;
    hw(A_CMD, BASE - 1);
    @(negedge clk);
    chk("R4 below base no read", 64'(nrd - r0), 0);
    rd(A_HI, r); chk("R7 hi after bad read", 64'(r), 64'(VEC[0][63:32]));
    repeat (4) @(negedge clk);
    hw(A_IEN, 1);
    hw(A_LO, 32'hCAFE_F00D);
    rd(A_HI, r); chk("R7 hi held", 64'(r), 64'(VEC[0][63:32]));
    rd(A_LO, r); chk("R7 lo overwritten", 64'(r), 64'hCAFE_F00D);

    hw(A_RST, 0);
    rd(A_STS, r); chk("R6 err cleared", 64'(r), 0);
    chk("R6 irq low", {63'b0, irq}, 0);

    w0 = nwr;
    hw(A_HI, 32'h5555_5555);
    hw(A_LO, 32'hAAAA_AAAA);
    hw(A_CMD, WR | (BASE + 2));
    hw(A_RST, 0);
    @(negedge clk);
    chk("R6 cancel no write", 64'(nwr - w0), 0);
    fetch(2, v);
    chk("R6 bank untouched", v, VEC[2][63:0]);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule